// File: doc/BRIEF.md
# Segment/Page Address Translation Front End

This block sits at the entry of a memory management unit. Each access arrives with a 32-bit virtual address, an access kind (read, write or execute), a user/kernel flag, and four configuration words: a global configuration word, an MMU configuration word and two packed kernel segment-base words. The block chooses one of three outcomes. If translation is switched off, the physical address is the virtual address. If the access comes from kernel mode and the 256 MB segment it falls in is marked as direct-mapped, the top nibble of the address is replaced by a base nibble taken from the packed base words. In every other case the access is forwarded to the paged TLB lookup, and that lookup's result is passed back unchanged.

The inputs are captured in a register when a request is accepted. Identity and segment results are computed from the captured values and presented with a single-cycle response strobe in the cycle after acceptance. Paged accesses raise a one-cycle lookup request in that cycle, tagged with the translation side (instruction side for execute, data side otherwise), and the response is returned in the cycle the lookup reports completion. A new request is accepted only while the block is idle.

Top module: `seg_page_xlate`

## Requirements
- R1: When bits 2 and 3 of the global configuration word are both zero, the response carries physical address equal to the virtual address, permission code 3'b111 ({execute, write, read}), miss low and path code 0 (identity), for user and kernel accesses alike.
- R2: Translation counts as enabled when bit 2 or bit 3 of the global configuration word is set; either bit alone is enough.
- R3: With translation enabled, a kernel access (user flag low) is segment-mapped (path code 1) exactly when bit S of the MMU configuration word is set, where S is virtual address bits 31:28.
- R4: Segments 0 to 7 take their base nibble from the low base word and segments 8 to 15 from the high base word, in both cases from bits [(S mod 8)*4 +: 4].
- R5: A segment-mapped response carries physical address {base nibble, virtual address bits 27:0}, permission 3'b111 and miss low.
- R6: A user access with translation enabled always takes the paged path (path code 2), whatever the MMU configuration word holds.
- R7: A paged access raises the lookup request for exactly one cycle, the cycle after acceptance, carrying the captured virtual address, access kind (0 read, 1 write, 2 execute) and user flag; the instruction-side flag is high only for execute.
- R8: A paged response appears in the cycle the lookup's done input is high while waiting, with the lookup's physical address, permission and miss passed through, and path code 2; no response appears before done.
- R9: An identity or segment response is a single-cycle strobe in the cycle after acceptance, and no lookup request is raised for it.
- R10: The ready output is low from acceptance until the response cycle has ended; a request offered while ready is low is ignored and produces neither a response nor a lookup request.
- R11: After reset, ready is high and both the response strobe and the lookup request are low.
- R12: The miss output can be high only on a paged response.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | User-mode access |
| cfg_global | input | 32 | Global configuration word |
| cfg_mmu | input | 32 | MMU configuration word, one direct-map bit per segment |
| seg_base_lo | input | 32 | Packed base nibbles for segments 0 to 7 |
| seg_base_hi | input | 32 | Packed base nibbles for segments 8 to 15 |
| lkp_req | output | 1 | Paged lookup request strobe |
| lkp_vaddr | output | 32 | Virtual address for the lookup |
| lkp_acc | output | 2 | Access kind for the lookup |
| lkp_user | output | 1 | User flag for the lookup |
| lkp_iside | output | 1 | Lookup is on the instruction side |
| lkp_done | input | 1 | Lookup finished |
| lkp_paddr | input | 32 | Lookup physical address |
| lkp_perm | input | 3 | Lookup permission {execute, write, read} |
| lkp_miss | input | 1 | Lookup failed |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permission {execute, write, read} |
| rsp_miss | output | 1 | Translation failed |
| rsp_path | output | 2 | 0 identity, 1 segment, 2 paged |

## Verification
The bench targets the enable decode with each of bits 2 and 3 alone and with neighbouring bits set, where a design testing the wrong bits would translate when it should pass through or the reverse. It drives segments 7 and 8 and the extreme segments 0 and 15, where a wrong half-select or nibble offset returns the wrong top nibble, and user accesses into direct-mapped segments, which a design ignoring the mode flag would wrongly segment-map. Paged accesses with lookup delays of zero to several cycles and a request offered during the wait catch a design that answers early, drops the lookup's miss, or accepts a second request while busy.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   localparam int        PERM_W   = 3;
   localparam logic [2:0] PERM_ALL = 3'b111;

   localparam logic [1:0] ACC_READ  = 2'd0;
   localparam logic [1:0] ACC_WRITE = 2'd1;
   localparam logic [1:0] ACC_EXEC  = 2'd2;

   localparam logic [1:0] PATH_IDENT = 2'd0;
   localparam logic [1:0] PATH_SEG   = 2'd1;
   localparam logic [1:0] PATH_PAGE  = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EVAL = 2'd1,
      ST_WAIT = 2'd2
   } xlate_state_e;
endpackage

// File: rtl/xlate_mode_decode.sv
module xlate_mode_decode
   import xlate_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int SEG_W      = 4,
   parameter int CFG_W      = 32,
   parameter logic [CFG_W-1:0] EN_MASK = 'hC,
   parameter bit SEG_ENABLE = 1'b1
) (
   input  logic [VA_W-1:0]  vaddr,
   input  logic             user,
   input  logic [CFG_W-1:0] gcfg,
   input  logic [CFG_W-1:0] mcfg,
   output logic [SEG_W-1:0] seg_idx,
   output logic [1:0]       path
);
   localparam int NUM_SEG = 1 << SEG_W;

   logic mmu_on;
   logic seg_hit;

   assign seg_idx = vaddr[VA_W-1 -: SEG_W];
   assign mmu_on  = |(gcfg & EN_MASK);

   generate
      if (SEG_ENABLE) begin : g_seg
         logic [NUM_SEG-1:0] seg_bits;
         assign seg_bits = mcfg[NUM_SEG-1:0];
         assign seg_hit  = seg_bits[seg_idx] & ~user;
      end else begin : g_noseg
         assign seg_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!mmu_on)      path = PATH_IDENT;
      else if (seg_hit) path = PATH_SEG;
      else              path = PATH_PAGE;
   end
endmodule

// File: rtl/seg_base_mux.sv
module seg_base_mux #(
   parameter int VA_W  = 32,
   parameter int SEG_W = 4
) (
   input  logic [SEG_W-1:0]                    seg_idx,
   input  logic [VA_W-1:0]                     vaddr,
   input  logic [((1 << SEG_W) / 2)*SEG_W-1:0] base_lo,
   input  logic [((1 << SEG_W) / 2)*SEG_W-1:0] base_hi,
   output logic [VA_W-1:0]                     seg_paddr
);
   localparam int NUM_SEG = 1 << SEG_W;
   localparam int HALF    = NUM_SEG / 2;

   logic [SEG_W-1:0] nib_tab [NUM_SEG];
   logic [SEG_W-1:0] nib;

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_tab
      if (g < HALF) begin : g_lo
         assign nib_tab[g] = base_lo[g*SEG_W +: SEG_W];
      end else begin : g_hi
         assign nib_tab[g] = base_hi[(g-HALF)*SEG_W +: SEG_W];
      end
   end

   assign nib       = nib_tab[seg_idx];
   assign seg_paddr = {nib, vaddr[VA_W-SEG_W-1:0]};
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
   import xlate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic is_page,
   input  logic done,
   output logic idle,
   output logic in_eval,
   output logic in_wait
);
   xlate_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (take) st_d = ST_EVAL;
         ST_EVAL: st_d = is_page ? ST_WAIT : ST_IDLE;
         ST_WAIT: if (done) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign idle    = (st_q == ST_IDLE);
   assign in_eval = (st_q == ST_EVAL);
   assign in_wait = (st_q == ST_WAIT);
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
   import xlate_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int SEG_W      = 4,
   parameter int CFG_W      = 32,
   parameter logic [CFG_W-1:0] EN_MASK = 'hC,
   parameter bit SEG_ENABLE = 1'b1,
   localparam int BASE_W    = ((1 << SEG_W) / 2) * SEG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [1:0]        req_acc,
   input  logic              req_user,
   input  logic [CFG_W-1:0]  cfg_global,
   input  logic [CFG_W-1:0]  cfg_mmu,
   input  logic [BASE_W-1:0] seg_base_lo,
   input  logic [BASE_W-1:0] seg_base_hi,
   output logic              lkp_req,
   output logic [VA_W-1:0]   lkp_vaddr,
   output logic [1:0]        lkp_acc,
   output logic              lkp_user,
   output logic              lkp_iside,
   input  logic              lkp_done,
   input  logic [VA_W-1:0]   lkp_paddr,
   input  logic [PERM_W-1:0] lkp_perm,
   input  logic              lkp_miss,
   output logic              rsp_valid,
   output logic [VA_W-1:0]   rsp_paddr,
   output logic [PERM_W-1:0] rsp_perm,
   output logic              rsp_miss,
   output logic [1:0]        rsp_path
);
   localparam int NUM_SEG = 1 << SEG_W;

   if (VA_W <= SEG_W) begin : g_chk_va
      $error("VA_W must exceed SEG_W");
   end
   if (CFG_W < NUM_SEG) begin : g_chk_cfg
      $error("CFG_W must hold one bit per segment");
   end

   logic              take;
   logic              idle, in_eval, in_wait;
   logic [VA_W-1:0]   q_vaddr;
   logic [1:0]        q_acc;
   logic              q_user;
   logic [CFG_W-1:0]  q_gcfg, q_mcfg;
   logic [BASE_W-1:0] q_lo, q_hi;
   logic [SEG_W-1:0]  seg_idx;
   logic [1:0]        path;
   logic [VA_W-1:0]   seg_paddr;

   assign take = req_valid & idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vaddr <= '0;
         q_acc   <= ACC_READ;
         q_user  <= 1'b0;
         q_gcfg  <= '0;
         q_mcfg  <= '0;
         q_lo    <= '0;
         q_hi    <= '0;
      end else if (take) begin
         q_vaddr <= req_vaddr;
         q_acc   <= req_acc;
         q_user  <= req_user;
         q_gcfg  <= cfg_global;
         q_mcfg  <= cfg_mmu;
         q_lo    <= seg_base_lo;
         q_hi    <= seg_base_hi;
      end
   end

   xlate_mode_decode #(
      .VA_W(VA_W), .SEG_W(SEG_W), .CFG_W(CFG_W),
      .EN_MASK(EN_MASK), .SEG_ENABLE(SEG_ENABLE)
   ) u_dec (
      .vaddr(q_vaddr), .user(q_user), .gcfg(q_gcfg), .mcfg(q_mcfg),
      .seg_idx(seg_idx), .path(path)
   );

   seg_base_mux #(.VA_W(VA_W), .SEG_W(SEG_W)) u_base (
      .seg_idx(seg_idx), .vaddr(q_vaddr),
      .base_lo(q_lo), .base_hi(q_hi), .seg_paddr(seg_paddr)
   );

   xlate_seq u_seq (
      .clk(clk), .rst_n(rst_n), .take(take),
      .is_page(path == PATH_PAGE), .done(lkp_done),
      .idle(idle), .in_eval(in_eval), .in_wait(in_wait)
   );

   assign req_ready = idle;

   assign lkp_req   = in_eval & (path == PATH_PAGE);
   assign lkp_vaddr = q_vaddr;
   assign lkp_acc   = q_acc;
   assign lkp_user  = q_user;
   assign lkp_iside = (q_acc == ACC_EXEC);

   always_comb begin
      rsp_valid = 1'b0;
      rsp_paddr = q_vaddr;
      rsp_perm  = PERM_ALL;
      rsp_miss  = 1'b0;
      rsp_path  = path;
      if (in_wait) begin
         rsp_valid = lkp_done;
         rsp_paddr = lkp_paddr;
         rsp_perm  = lkp_perm;
         rsp_miss  = lkp_done & lkp_miss;
         rsp_path  = PATH_PAGE;
      end else if (in_eval && path != PATH_PAGE) begin
         rsp_valid = 1'b1;
         if (path == PATH_SEG) rsp_paddr = seg_paddr;
      end
   end
endmodule

// File: rtl/seg_page_xlate_chk.sv
module seg_page_xlate_chk #(
   parameter int VA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [VA_W-1:0] req_vaddr,
   input logic            lkp_req,
   input logic            rsp_valid,
   input logic [VA_W-1:0] rsp_paddr,
   input logic [2:0]      rsp_perm,
   input logic            rsp_miss,
   input logic [1:0]      rsp_path
);
   // R9: direct response arrives the cycle after acceptance, or R7 lookup does
   p_accept_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid || lkp_req));

   // R7: lookup request lasts one cycle
   p_lkp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_req |=> !lkp_req);

   // R9: direct response is a single-cycle strobe
   p_direct_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_path != 2'd2) |=> !rsp_valid);

   // R5: direct responses grant everything and never miss
   p_direct_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_path != 2'd2) |-> (rsp_perm == 3'b111 && !rsp_miss));

   // R12: miss only on the paged path
   p_miss_paged_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> (rsp_valid && rsp_path == 2'd2));

   // R1: identity response returns the accepted address
   p_ident_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_path == 2'd0) |-> rsp_paddr == $past(req_vaddr));

   // R10: never ready while a response is being given
   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
endmodule

bind seg_page_xlate seg_page_xlate_chk #(.VA_W(VA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_vaddr(req_vaddr), .lkp_req(lkp_req), .rsp_valid(rsp_valid),
   .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_miss(rsp_miss),
   .rsp_path(rsp_path)
);

// File: tb/seg_page_xlate_test.sv
`timescale 1ns/1ps
module seg_page_xlate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic [31:0] cfg_global = '0, cfg_mmu = '0, seg_base_lo = '0, seg_base_hi = '0;
   logic        lkp_req;
   logic [31:0] lkp_vaddr;
   logic [1:0]  lkp_acc;
   logic        lkp_user, lkp_iside;
   logic        lkp_done = 1'b0;
   logic [31:0] lkp_paddr = '0;
   logic [2:0]  lkp_perm = '0;
   logic        lkp_miss = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_perm;
   logic        rsp_miss;
   logic [1:0]  rsp_path;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   seg_page_xlate uut (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] m_path(logic [31:0] va, logic usr, logic [31:0] g, logic [31:0] m);
      if (g[3:2] == 2'b00)      return 2'd0;
      if (!usr && m[va[31:28]]) return 2'd1;
      return 2'd2;
   endfunction

   function automatic logic [31:0] m_seg(logic [31:0] va, logic [31:0] lo, logic [31:0] hi);
      logic [3:0]  s = va[31:28];
      logic [31:0] b = (s < 4'd8) ? lo : hi;
      logic [3:0]  n = b[{s[2:0], 2'b00} +: 4];
      return {n, va[27:0]};
   endfunction

   // One access; lat = lookup delay in cycles for paged accesses
   task automatic access(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                         input logic [31:0] g, input logic [31:0] m,
                         input logic [31:0] lo, input logic [31:0] hi,
                         input int lat, input bit poke_busy, input string tag);
      logic [1:0]  ep = m_path(va, usr, g, m);
      logic [31:0] tp = {va[31:4] ^ 28'h5A5A5A5, 4'h3};
      logic        tm = va[4];
      logic [2:0]  tperm = va[7:5];
      @(negedge clk);
      chk(req_ready == 1'b1, {tag, " R10 ready idle"}, 32'(req_ready), 1);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr;
      cfg_global = g; cfg_mmu = m; seg_base_lo = lo; seg_base_hi = hi;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, {tag, " R10 busy"}, 32'(req_ready), 0);
      if (ep != 2'd2) begin
         chk(rsp_valid && lkp_req == 1'b0, {tag, " R9 strobe"}, {rsp_valid, lkp_req}, 2'b10);
         chk(rsp_path == ep, {tag, " R3 path"}, 32'(rsp_path), 32'(ep));
         if (ep == 2'd0)
            chk(rsp_paddr == va, {tag, " R1 identity addr"}, rsp_paddr, va);
         else
            chk(rsp_paddr == m_seg(va, lo, hi), {tag, " R4 R5 segment addr"}, rsp_paddr, m_seg(va, lo, hi));
         chk(rsp_perm == 3'b111 && !rsp_miss, {tag, " R5 perm/miss"}, {rsp_perm, rsp_miss}, 4'b1110);
         @(negedge clk);
         chk(!rsp_valid, {tag, " R9 single strobe"}, 32'(rsp_valid), 0);
      end else begin
         chk(lkp_req && !rsp_valid, {tag, " R6 R7 lookup raised"}, {lkp_req, rsp_valid}, 2'b10);
         chk(lkp_vaddr == va && lkp_acc == acc && lkp_user == usr,
             {tag, " R7 lookup fields"}, {lkp_vaddr[28:0], lkp_acc, lkp_user}, {va[28:0], acc, usr});
         chk(lkp_iside == (acc == 2'd2), {tag, " R7 iside"}, 32'(lkp_iside), 32'(acc == 2'd2));
         @(negedge clk);
         chk(!lkp_req, {tag, " R7 lookup pulse"}, 32'(lkp_req), 0);
         for (int k = 0; k < lat; k++) begin
            if (poke_busy && k == 0) begin
               req_valid = 1'b1; req_vaddr = ~va; req_user = 1'b0; cfg_global = 0;
            end
            chk(!rsp_valid && !req_ready, {tag, " R8 R10 wait"}, {rsp_valid, req_ready}, 0);
            @(negedge clk);
            req_valid = 1'b0;
         end
         lkp_done = 1'b1; lkp_paddr = tp; lkp_miss = tm; lkp_perm = tperm;
         #0.5;
         chk(rsp_valid && rsp_path == 2'd2, {tag, " R8 paged resp"}, {rsp_valid, rsp_path}, 3'b110);
         chk(rsp_paddr == tp && rsp_perm == tperm, {tag, " R8 pass-through"}, rsp_paddr, tp);
         chk(rsp_miss == tm, {tag, " R12 miss pass"}, 32'(rsp_miss), 32'(tm));
         @(negedge clk);
         lkp_done = 1'b0; lkp_miss = 1'b0;
         #0.5;
         chk(!rsp_valid && !lkp_req && req_ready, {tag, " R10 request ignored"},
             {rsp_valid, lkp_req, req_ready}, 3'b001);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] lo_d = 32'h76543210;
      logic [31:0] hi_d = 32'hFEDCBA98;
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready && !rsp_valid && !lkp_req, "R11 reset state",
          {req_ready, rsp_valid, lkp_req}, 3'b100);
      rst_n = 1'b1;

      // R1: disabled, kernel and user, other config bits set
      access(32'hDEADBEEF, 2'd0, 1'b0, 32'hFFFF_FFF3, 32'hFFFF, lo_d, hi_d, 0, 0, "R1 kern");
      access(32'h1234_5678, 2'd2, 1'b1, 32'h0, 32'hFFFF, lo_d, hi_d, 0, 0, "R1 user");
      // R2: each enable bit alone
      access(32'h8000_1000, 2'd0, 1'b0, 32'h4, 32'h0, lo_d, hi_d, 1, 0, "R2 bit2");
      access(32'h8000_1000, 2'd1, 1'b0, 32'h8, 32'h0, lo_d, hi_d, 0, 0, "R2 bit3");
      // R3/R4: boundary segments
      access(32'h7ABC_DEF0, 2'd0, 1'b0, 32'h4, 32'h0080, 32'hA000_0000, hi_d, 0, 0, "R4 seg7");
      access(32'h8ABC_DEF0, 2'd0, 1'b0, 32'h4, 32'h0100, lo_d, 32'h0000_0005, 0, 0, "R4 seg8");
      access(32'h0000_0010, 2'd2, 1'b0, 32'h8, 32'h0001, 32'h0000_000C, hi_d, 0, 0, "R4 seg0");
      access(32'hF123_4567, 2'd1, 1'b0, 32'hC, 32'h8000, lo_d, 32'h3000_0000, 0, 0, "R4 seg15");
      // R3: neighbouring bit set but own bit clear -> paged
      access(32'h5000_0000, 2'd0, 1'b0, 32'h4, 32'hFFDF, lo_d, hi_d, 2, 0, "R3 own bit clear");
      // R6: user into direct-mapped segment
      access(32'h3000_2000, 2'd2, 1'b1, 32'h4, 32'hFFFF, lo_d, hi_d, 3, 1, "R6 user");
      // R10: busy poke with delays
      access(32'hC000_0010, 2'd1, 1'b0, 32'h8, 32'h0, lo_d, hi_d, 4, 1, "R10 poke");

      for (int i = 0; i < 300; i++) begin
         logic [31:0] g = ($urandom % 4 == 0) ? ($urandom & 32'hFFFF_FFF3) : ($urandom | 32'h4);
         access($urandom, 2'($urandom % 3), 1'($urandom), g, $urandom, $urandom, $urandom,
                int'($urandom % 4), 1'($urandom), "rand");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule